// File: doc/BRIEF.md
# DRAM Row/Column Strobe Sequencer

This block turns a single processor access request into the strobe sequence a DRAM needs. When an address strobe and a chip select are seen together on a rising clock edge, the block asserts the row strobe and drives the row half of the address onto a shared address bus. After a programmed hold time it switches the bus to the column half. One edge later it asserts the column strobe. It then returns a one-cycle data acknowledge.

The block works only in the non-page style. The row strobe times out on its own after a programmed number of clocks. The block then enforces a programmed precharge gap before the row strobe may fall again. A request that arrives during that gap is remembered and started as soon as the gap has passed. Requests that arrive while an access is in progress are dropped.

All four timing fields are 2-bit input ports, each encoding `field + 1` clocks. They are captured when an access starts. An optional latch mode freezes the column address at the edge where the request is registered. Without it, the column half of the bus follows the column input.

Top module: `dram_seq_top`

## Requirements
- R1: While and after a synchronous reset with no request, ras_n=1, cas_n=1, ack=0 and mux_addr=0 (row register cleared), and precharge counts as already met.
- R2: A start happens on edge E when addr_strobe=1 and chip_sel=1 are sampled, no access is in progress and precharge is met. From E, ras_n=0 and mux_addr carries row_addr. With chip_sel=0 nothing starts.
- R3: ras_n stays low for ras_cfg+1 clocks and rises on edge E+ras_cfg+1 with no further input.
- R4: mux_addr switches from the row to the column address on edge E+hold_cfg+1. cas_n falls one edge later, on E+hold_cfg+2.
- R5: ack rises on edge E+K, where K = max(ack_cfg+1, hold_cfg+2), and stays high for exactly one clock.
- R6: On edge E+K+1, ack falls and cas_n rises together, the access ends and mux_addr returns to the captured row address.
- R7: If ras_n rose on edge N, the next start is no earlier than edge N+pre_cfg+1. A request sampled before that edge is held and starts on the first edge at which precharge is met, using the row and column captured when it was sampled.
- R8: A request sampled on any edge from E through E+K+1 has no effect: no later access starts from it.
- R9: With latch_en=1, the column address shown is the col_addr sampled at the edge where the request was registered. With latch_en=0, mux_addr shows the col_addr sampled at each edge of the column phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strobe | input | 1 | Address strobe, active high |
| chip_sel | input | 1 | Chip select, active high |
| row_addr | input | ADDR_W | Row half of the access address |
| col_addr | input | ADDR_W | Column half of the access address |
| hold_cfg | input | 2 | Row hold before the column switch, clocks minus one |
| ras_cfg | input | 2 | Row strobe low time, clocks minus one |
| ack_cfg | input | 2 | Acknowledge delay after the row strobe, clocks minus one |
| pre_cfg | input | 2 | Precharge gap, clocks minus one |
| latch_en | input | 1 | 1 = hold the column captured with the request, 0 = follow col_addr |
| mux_addr | output | ADDR_W | Multiplexed row/column address bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ack | output | 1 | One-cycle data acknowledge |

## Verification
The bench uses hold/ack settings where the hold time wins and settings where the ack delay wins. A design that put out ack before cas_n fell, or that took ack from the ack field alone, is caught there. Requests placed just after an access ends check the precharge gap. A design that failed to hold such a request, or started it early, shows ras_n falling on the wrong edge or never falling. A row value changed after such a request would also appear on the bus. A request made during an access and a strobe without chip select must leave ras_n high, which catches a pending flag set while busy. Changing col_addr inside the column window tells the latch path from the transparent path.

// File: rtl/dram_seq_pkg.sv
// Shared constants for the DRAM strobe sequencer.
// Assumes every timing field is CFG_W bits and means field+1 clocks.
package dram_seq_pkg;
    localparam int CFG_W   = 2;
    // Longest elapsed count: ack limit (hold+2) plus the end edge.
    localparam int MAX_CNT = (1 << CFG_W) + 2;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Convert an encoded field into a clock count.
    function automatic cnt_t cfg_clocks(input cfg_t f);
        return cnt_t'(f) + cnt_t'(1);
    endfunction
endpackage

// File: rtl/dram_seq_ras.sv
// Row-strobe timer with precharge tracking.
// Drives ras_n low on start and raises it after the programmed low time.
// Then counts the precharge gap and reports pre_ok once a new start is allowed.
// Assumes start is only given while pre_ok is high.
module dram_seq_ras
    import dram_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  cfg_t ras_cfg,
    input  cfg_t pre_cfg,
    output logic ras_n,
    output logic pre_ok
);
    cnt_t ras_left;
    cnt_t pre_left;
    cfg_t pre_q;

    // Row strobe low-time and precharge countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n    <= 1'b1;
            ras_left <= '0;
            pre_left <= '0;
            pre_q    <= '0;
        end else if (start) begin
            ras_n    <= 1'b0;
            ras_left <= cfg_clocks(ras_cfg);
            pre_q    <= pre_cfg;
        end else if (!ras_n) begin
            if (ras_left == cnt_t'(1)) begin
                ras_n    <= 1'b1;
                pre_left <= cfg_clocks(pre_q);
            end else begin
                ras_left <= ras_left - cnt_t'(1);
            end
        end else if (pre_left != '0) begin
            pre_left <= pre_left - cnt_t'(1);
        end
    end

    // Start is allowed once the strobe is high and the gap has elapsed.
    assign pre_ok = ras_n && (pre_left <= cnt_t'(1));

    // R7
    prech_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(pre_left) <= cnt_t'(1)));
endmodule

// File: rtl/dram_seq_cyc.sv
// Column-phase sequencer: tracks clocks since start and places the
// column switch, the column strobe, the acknowledge and the end of access.
// Assumes start is never given while busy.
module dram_seq_cyc
    import dram_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  cfg_t hold_cfg,
    input  cfg_t ack_cfg,
    output logic busy,
    output logic col_go,
    output logic col_on,
    output logic fin,
    output logic cas_n,
    output logic ack
);
    cnt_t cnt;
    cnt_t hold_lim;
    cnt_t ack_lim;
    cnt_t ack_req;
    cnt_t cas_at;

    // Limits for the access being started; ack waits for the column strobe.
    always_comb begin
        ack_req = cfg_clocks(ack_cfg);
        cas_at  = cfg_clocks(hold_cfg) + cnt_t'(1);
    end

    // Elapsed-clock counter and strobe/ack registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            hold_lim <= '0;
            ack_lim  <= '0;
            col_on   <= 1'b0;
            cas_n    <= 1'b1;
            ack      <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= cnt_t'(1);
            hold_lim <= cfg_clocks(hold_cfg);
            ack_lim  <= (ack_req > cas_at) ? ack_req : cas_at;
        end else if (busy) begin
            cnt <= cnt + cnt_t'(1);
            if (cnt == hold_lim)
                col_on <= 1'b1;
            if (cnt == hold_lim + cnt_t'(1))
                cas_n <= 1'b0;
            if (cnt == ack_lim)
                ack <= 1'b1;
            if (fin) begin
                ack    <= 1'b0;
                cas_n  <= 1'b1;
                busy   <= 1'b0;
                col_on <= 1'b0;
            end
        end
    end

    // Edge events seen by the address path.
    assign col_go = busy && (cnt == hold_lim);
    assign fin    = busy && (cnt == ack_lim + cnt_t'(1));

    // R4
    cas_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(col_on));
    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R5
    ack_under_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !cas_n);
    // R6
    ack_cas_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $rose(cas_n));
endmodule

// File: rtl/dram_seq_addr.sv
// Address path: captures the row (always) and the column (for latch mode)
// when a request is registered, and drives the registered multiplexed bus.
// Assumes col_go/col_on/fin come from the column-phase sequencer.
module dram_seq_addr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              start,
    input  logic              use_held,
    input  logic              latch_en,
    input  logic              col_go,
    input  logic              col_on,
    input  logic              fin,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic [ADDR_W-1:0] col_addr,
    output logic [ADDR_W-1:0] mux_addr
);
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic [ADDR_W-1:0] col_src;

    // Column source: frozen copy in latch mode, live input otherwise.
    assign col_src = latch_en ? col_q : col_addr;

    // Capture the request's address halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (capture) begin
            row_q <= row_addr;
            col_q <= col_addr;
        end
    end

    // Multiplexed address bus register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mux_addr <= '0;
        else if (start)
            mux_addr <= use_held ? row_q : row_addr;
        else if (fin)
            mux_addr <= row_q;
        else if (col_go || col_on)
            mux_addr <= col_src;
    end
endmodule

// File: rtl/dram_seq_top.sv
// DRAM row/column strobe sequencer, non-page mode.
// Accepts a request when strobe and chip select are both high, remembers
// a request that must wait for precharge, and drops requests made during
// an access. Assumes timing fields are stable for one clock around start.
module dram_seq_top
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strobe,
    input  logic              chip_sel,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic [ADDR_W-1:0] col_addr,
    input  logic [CFG_W-1:0]  hold_cfg,
    input  logic [CFG_W-1:0]  ras_cfg,
    input  logic [CFG_W-1:0]  ack_cfg,
    input  logic [CFG_W-1:0]  pre_cfg,
    input  logic              latch_en,
    output logic [ADDR_W-1:0] mux_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              ack
);
    logic req;
    logic pend;
    logic busy;
    logic pre_ok;
    logic start;
    logic capture;
    logic col_go;
    logic col_on;
    logic fin;

    // Request qualification and start decision.
    assign req     = addr_strobe && chip_sel;
    assign start   = !busy && (req || pend) && pre_ok;
    assign capture = req && !busy && !pend;

    // Pending flag for a request that waits on precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (start)
            pend <= 1'b0;
        else if (req && !busy)
            pend <= 1'b1;
    end

    dram_seq_ras u_ras (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ras_cfg (ras_cfg),
        .pre_cfg (pre_cfg),
        .ras_n   (ras_n),
        .pre_ok  (pre_ok)
    );

    dram_seq_cyc u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .hold_cfg (hold_cfg),
        .ack_cfg  (ack_cfg),
        .busy     (busy),
        .col_go   (col_go),
        .col_on   (col_on),
        .fin      (fin),
        .cas_n    (cas_n),
        .ack      (ack)
    );

    dram_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .start    (start),
        .use_held (pend),
        .latch_en (latch_en),
        .col_go   (col_go),
        .col_on   (col_on),
        .fin      (fin),
        .row_addr (row_addr),
        .col_addr (col_addr),
        .mux_addr (mux_addr)
    );

    // R2
    ras_on_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !col_on);
    // R8
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy |-> ras_n || !$fell(ras_n));
    // R7
    held_until_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !pre_ok |=> ras_n || !$fell(ras_n));
endmodule

// File: tb/dram_seq_top_tb.sv
`timescale 1ns/1ps
module dram_seq_top_tb;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_strobe = 1'b0;
    logic          chip_sel = 1'b0;
    logic [AW-1:0] row_addr = '0;
    logic [AW-1:0] col_addr = '0;
    logic [1:0]    hold_cfg = '0;
    logic [1:0]    ras_cfg = '0;
    logic [1:0]    ack_cfg = '0;
    logic [1:0]    pre_cfg = '0;
    logic          latch_en = 1'b0;
    logic [AW-1:0] mux_addr;
    logic          ras_n;
    logic          cas_n;
    logic          ack;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dram_seq_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .chip_sel(chip_sel),
        .row_addr(row_addr), .col_addr(col_addr), .hold_cfg(hold_cfg),
        .ras_cfg(ras_cfg), .ack_cfg(ack_cfg), .pre_cfg(pre_cfg),
        .latch_en(latch_en), .mux_addr(mux_addr), .ras_n(ras_n),
        .cas_n(cas_n), .ack(ack)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        addr_strobe = 1'b0;
        chip_sel = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1: reset values.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ras_n", ras_n, 1);
        chk("R1 cas_n", cas_n, 1);
        chk("R1 ack", ack, 0);
        chk("R1 mux", mux_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ras_n after", ras_n, 1);
    endtask

    // R2..R6, R9: one access, checked at every edge of its life.
    task automatic t_access(input int h, input int r, input int a, input int p,
                            input bit lat, input logic [AW-1:0] row,
                            input logic [AW-1:0] c1, input logic [AW-1:0] c2);
        int hh, rl, ak;
        logic [AW-1:0] colv;
        hold_cfg = 2'(h); ras_cfg = 2'(r); ack_cfg = 2'(a); pre_cfg = 2'(p);
        latch_en = lat;
        idle(10);
        hh = h + 1; rl = r + 1;
        ak = (a + 1 > h + 2) ? a + 1 : h + 2;
        colv = lat ? c1 : c2;
        addr_strobe = 1'b1; chip_sel = 1'b1; row_addr = row; col_addr = c1;
        @(negedge clk);
        addr_strobe = 1'b0; chip_sel = 1'b0; col_addr = c2;
        for (int k = 0; k <= ak + 2; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 0) chk("R2 ras_n low at start", ras_n, 0);
            else chk("R3 ras_n", ras_n, (k < rl) ? 0 : 1);
            if (k < hh) chk("R2 mux row", mux_addr, row);
            else if (k <= ak) chk(lat ? "R9 mux col latched" : "R9 mux col live", mux_addr, colv);
            else chk("R6 mux row after end", mux_addr, row);
            if (k <= ak) chk("R4 cas_n", cas_n, (k >= hh + 1) ? 0 : 1);
            else chk("R6 cas_n end", cas_n, 1);
            chk("R5 ack", ack, (k == ak) ? 1 : 0);
        end
    endtask

    // R7: request right after an access waits out precharge.
    task automatic t_prech(input int r, input int p, input logic [AW-1:0] row2);
        int rl, s;
        hold_cfg = 2'd0; ack_cfg = 2'd0; ras_cfg = 2'(r); pre_cfg = 2'(p);
        latch_en = 1'b0;
        idle(10);
        rl = r + 1;
        s = (rl + p + 1 > 4) ? rl + p + 1 : 4;
        addr_strobe = 1'b1; chip_sel = 1'b1; row_addr = 10'h011; col_addr = 10'h022;
        @(negedge clk);
        addr_strobe = 1'b0; chip_sel = 1'b0;
        for (int k = 0; k <= s; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 3) begin
                addr_strobe = 1'b1; chip_sel = 1'b1; row_addr = row2;
            end
            if (k == 4) begin
                addr_strobe = 1'b0; chip_sel = 1'b0; row_addr = 10'h3ff;
            end
            if (k >= 4) chk("R7 ras_n around precharge", ras_n, (k >= s) ? 0 : 1);
            if (k == s) chk("R7 held row used", mux_addr, row2);
        end
    endtask

    // R8 and R2: requests during an access and strobes without chip select.
    task automatic t_ignore();
        hold_cfg = 2'd1; ack_cfg = 2'd3; ras_cfg = 2'd1; pre_cfg = 2'd0;
        latch_en = 1'b0;
        idle(10);
        addr_strobe = 1'b1; chip_sel = 1'b1; row_addr = 10'h055;
        @(negedge clk);
        addr_strobe = 1'b0; chip_sel = 1'b0;
        @(negedge clk);
        addr_strobe = 1'b1; chip_sel = 1'b1; row_addr = 10'h0aa;
        repeat (3) @(negedge clk);
        addr_strobe = 1'b0; chip_sel = 1'b0;
        for (int k = 5; k <= 12; k++) begin
            @(negedge clk);
            chk("R8 no access from busy request", ras_n, 1);
        end
        chk("R8 cas_n idle", cas_n, 1);
        addr_strobe = 1'b1; chip_sel = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 no start without chip_sel", ras_n, 1);
        end
        addr_strobe = 1'b0;
    endtask

    initial begin
        t_reset();
        t_access(0, 1, 0, 0, 1'b0, 10'h123, 10'h0f0, 10'h0f1);
        t_access(2, 3, 0, 1, 1'b0, 10'h2a5, 10'h111, 10'h222);
        t_access(0, 0, 3, 3, 1'b1, 10'h35a, 10'h0c3, 10'h13c);
        t_access(1, 2, 3, 2, 1'b1, 10'h077, 10'h301, 10'h102);
        t_access(3, 3, 3, 3, 1'b0, 10'h1ee, 10'h0ab, 10'h0cd);
        t_prech(3, 3, 10'h2b4);
        t_prech(1, 2, 10'h15e);
        t_prech(3, 0, 10'h0d1);
        t_ignore();
        idle(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule